// File: doc/BRIEF.md
# Host Frame Injection Port

This block lets a host processor hand a frame to a switch fabric through a small register bus. The host first writes a framing command, then writes payload words of 8 or 16 bits to the data register. Each accepted payload write becomes one to two bytes on a byte-wide valid/ready stream. The stream carries start, end and abort markers that come from the command in force when the word was written.

The end codes say how many bytes of the last word are real, so a frame of odd length needs no separate length field. A start code turns into the middle code by itself after its first data write. An end code turns into idle after its data write. A command that makes no sense in the current frame state is refused, and it sets a sticky error flag. A separate strobe register produces a one-cycle pulse that drops the received frame the host has not yet read. When the stream stalls, data and command writes are held on the bus by a wait signal. Drop and error-clear writes always go through at once.

Top module: `pkt_inject_port`

## Requirements
- R1: After reset, out_valid, bus_wait, drop_pulse and err_flag are 0 and the command is idle, so a data write made right after reset emits nothing and sets err_flag.
- R2: Registers sit at bus_addr 0 (data), 1 (command, bits 2:0), 2 (drop strobe) and 3 (error clear). The command codes are 000 idle, 001 start, 010 middle, 011 abort, 100 end with two bytes left and 101 end with one byte left.
- R3: A data write under the start code emits its bytes with out_sop=1 on the first byte only, opens the frame and changes the command to middle.
- R4: A write with bus_wide=1 emits bus_wdata[7:0] first and then bus_wdata[15:8]. A write with bus_wide=0 emits bus_wdata[7:0] alone.
- R5: Under code 100 the write's bytes are emitted, and code 100 with an 8-bit write emits one byte. Under code 101 only bus_wdata[7:0] is emitted. In both cases out_eop=1 marks the last byte, the frame closes and the command returns to idle.
- R6: Code 011 written while a frame is open emits one byte with out_abort=1, data 8'h00, out_sop=0 and out_eop=0. It closes the frame and leaves the command idle. With no frame open it emits nothing and does not set err_flag.
- R7: These writes set err_flag and emit nothing: a data write while the command is idle; code 010, 100 or 101 with no open frame; code 001 while a frame is open. The last three leave the command unchanged. Codes 110 and 111 make the command idle and set err_flag. Any write to address 3 clears err_flag.
- R8: While bytes are still pending, a write to address 0 or 1 is held with bus_wait=1 and is not taken. While out_ready=0, out_valid, out_data and the markers stay stable.
- R9: A write to address 2 is taken even while bytes are pending. It raises drop_pulse for exactly the one cycle after it is taken and leaves the byte stream unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Bus write request, held until bus_wait is low |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_wide | input | 1 | 1 = 16-bit write, 0 = 8-bit write (low byte) |
| bus_wait | output | 1 | Hold the current write |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Stream sink ready |
| out_data | output | 8 | Stream byte |
| out_sop | output | 1 | First byte of a frame |
| out_eop | output | 1 | Last byte of a frame |
| out_abort | output | 1 | Frame abandoned marker beat |
| drop_pulse | output | 1 | One-cycle drop request for the pending received frame |
| err_flag | output | 1 | Sticky command/data misuse flag |

## Verification
The drop strobe and the stream drain are the two functions that can fall in the same cycle. Because a drop write bypasses the wait, the bench issues a 16-bit write and presents the drop write on the very next cycle. At that point the second byte of the word is still on the stream. In that cycle the bench samples drop_pulse, out_valid and out_data together. It then confirms that both bytes arrived in order and that exactly one drop pulse was seen.

// File: rtl/pkt_inject_pkg.sv
package pkt_inject_pkg;

  localparam logic [2:0] CMD_IDLE  = 3'b000;
  localparam logic [2:0] CMD_SOF   = 3'b001;
  localparam logic [2:0] CMD_MID   = 3'b010;
  localparam logic [2:0] CMD_ABORT = 3'b011;
  localparam logic [2:0] CMD_EOF2  = 3'b100;
  localparam logic [2:0] CMD_EOF1  = 3'b101;

  // codes 110 and 111 carry no meaning
  function automatic logic cmd_reserved(input logic [2:0] code);
    return code[2] & code[1];
  endfunction

  // codes that continue or close an already open frame
  function automatic logic cmd_needs_frame(input logic [2:0] code);
    return (code == CMD_MID) || (code == CMD_EOF2) || (code == CMD_EOF1);
  endfunction

  function automatic logic cmd_is_end(input logic [2:0] code);
    return (code == CMD_EOF2) || (code == CMD_EOF1);
  endfunction

  // bytes a data write yields: the one-byte end code keeps the low lane only,
  // otherwise a full-width write gives every lane and a narrow one gives one
  function automatic int unsigned beat_bytes(input logic [2:0] code,
                                             input logic full,
                                             input int unsigned lanes);
    if (code == CMD_EOF1) return 1;
    return full ? lanes : 1;
  endfunction

endpackage

// File: rtl/pkt_cmd_ctrl.sv
module pkt_cmd_ctrl
  import pkt_inject_pkg::*;
#(
  parameter int LANES = 2,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [2:0]       cmd_code,
  input  logic             dat_we,
  input  logic             dat_full,
  input  logic             clr_we,
  output logic             load,
  output logic [CNT_W-1:0] load_cnt,
  output logic             load_sop,
  output logic             load_eop,
  output logic             load_abort,
  output logic             frame_open,
  output logic             err_flag
);

  logic [2:0] cmd_q, cmd_d;
  logic       open_q, open_d;
  logic       err_q, err_d;

  // named events for the checks below
  logic ev_cmd_bad;   // refused command write
  logic ev_abort;     // abort of an open frame
  logic ev_dat_ign;   // data write under idle
  logic ev_dat_ok;    // data write that yields bytes

  always_comb begin
    ev_cmd_bad = cmd_we && (cmd_reserved(cmd_code)
                 || (cmd_needs_frame(cmd_code) && !open_q)
                 || ((cmd_code == CMD_SOF) && open_q));
    ev_abort   = cmd_we && (cmd_code == CMD_ABORT) && open_q;
    ev_dat_ign = dat_we && (cmd_q == CMD_IDLE);
    ev_dat_ok  = dat_we && (cmd_q != CMD_IDLE);
  end

  always_comb begin
    load       = ev_dat_ok || ev_abort;
    load_cnt   = ev_abort ? CNT_W'(1) : CNT_W'(beat_bytes(cmd_q, dat_full, LANES));
    load_sop   = ev_dat_ok && (cmd_q == CMD_SOF);
    load_eop   = ev_dat_ok && cmd_is_end(cmd_q);
    load_abort = ev_abort;
  end

  always_comb begin
    cmd_d  = cmd_q;
    open_d = open_q;
    err_d  = err_q;
    if (clr_we) err_d = 1'b0;
    if (ev_cmd_bad || ev_dat_ign) err_d = 1'b1;
    if (cmd_we) begin
      if (cmd_reserved(cmd_code) || (cmd_code == CMD_ABORT)) cmd_d = CMD_IDLE;
      else if (!ev_cmd_bad) cmd_d = cmd_code;
    end
    if (ev_abort) open_d = 1'b0;
    if (ev_dat_ok) begin
      if (cmd_q == CMD_SOF) begin
        cmd_d  = CMD_MID;
        open_d = 1'b1;
      end else if (cmd_is_end(cmd_q)) begin
        cmd_d  = CMD_IDLE;
        open_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= CMD_IDLE;
      open_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      open_q <= open_d;
      err_q  <= err_d;
    end
  end

  assign frame_open = open_q;
  assign err_flag   = err_q;

  a_r7_ignored_data_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dat_ign |=> err_flag);
  a_r7_refused_cmd_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmd_bad |=> err_flag);
  a_r6_abort_closes: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> !frame_open);
  a_r3_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_sop) |=> frame_open);

endmodule

// File: rtl/pkt_beat_buf.sv
module pkt_beat_buf #(
  parameter int LANES  = 2,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 2,
  parameter int IDX_W  = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [LANES*BYTE_W-1:0] load_data,
  input  logic [CNT_W-1:0]        load_cnt,
  input  logic                    load_sop,
  input  logic                    load_eop,
  input  logic                    load_abort,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic [BYTE_W-1:0]       out_data,
  output logic                    out_sop,
  output logic                    out_eop,
  output logic                    out_abort,
  output logic                    busy
);

  logic [BYTE_W-1:0] lane_q [LANES];
  logic [CNT_W-1:0]  remain_q;
  logic [IDX_W-1:0]  idx_q;
  logic              sop_q, eop_q, abort_q;
  logic              take;

  assign take = out_valid && out_ready;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) lane_q[g] <= '0;
      else if (load) lane_q[g] <= load_abort ? '0 : load_data[g*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q <= '0;
      idx_q    <= '0;
      sop_q    <= 1'b0;
      eop_q    <= 1'b0;
      abort_q  <= 1'b0;
    end else if (load) begin
      remain_q <= load_cnt;
      idx_q    <= '0;
      sop_q    <= load_sop;
      eop_q    <= load_eop;
      abort_q  <= load_abort;
    end else if (take) begin
      remain_q <= remain_q - CNT_W'(1);
      idx_q    <= idx_q + IDX_W'(1);
    end
  end

  assign busy      = (remain_q != '0);
  assign out_valid = busy;
  assign out_data  = lane_q[idx_q];
  assign out_sop   = busy && sop_q && (idx_q == '0);
  assign out_eop   = busy && eop_q && (remain_q == CNT_W'(1));
  assign out_abort = busy && abort_q;

  a_r8_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                   && $stable(out_sop) && $stable(out_eop)));
  a_r6_abort_alone: assert property (@(posedge clk) disable iff (!rst_n)
    out_abort |-> (!out_sop && !out_eop));
  a_r3_single_marker: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_sop, out_eop}));

endmodule

// File: rtl/pkt_inject_port.sv
module pkt_inject_port #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 3,
  parameter int A_DATA = 0,
  parameter int A_CMD  = 1,
  parameter int A_DROP = 2,
  parameter int A_CLR  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wide,
  output logic              bus_wait,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic              out_abort,
  output logic              drop_pulse,
  output logic              err_flag
);

  localparam int LANES = DATA_W / BYTE_W;
  localparam int CNT_W = $clog2(LANES + 1);
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic             hit_data, hit_cmd, hit_drop, hit_clr, accept;
  logic             busy, drop_q;
  logic             load, load_sop, load_eop, load_abort, frame_open;
  logic [CNT_W-1:0] load_cnt;

  assign hit_data = (bus_addr == ADDR_W'(A_DATA));
  assign hit_cmd  = (bus_addr == ADDR_W'(A_CMD));
  assign hit_drop = (bus_addr == ADDR_W'(A_DROP));
  assign hit_clr  = (bus_addr == ADDR_W'(A_CLR));

  // only writes that reach the framing logic wait for the stream to drain
  assign bus_wait = bus_wr && busy && (hit_data || hit_cmd);
  assign accept   = bus_wr && !bus_wait;

  pkt_cmd_ctrl #(.LANES(LANES), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_we    (accept && hit_cmd),
    .cmd_code  (bus_wdata[2:0]),
    .dat_we    (accept && hit_data),
    .dat_full  (bus_wide),
    .clr_we    (accept && hit_clr),
    .load      (load),
    .load_cnt  (load_cnt),
    .load_sop  (load_sop),
    .load_eop  (load_eop),
    .load_abort(load_abort),
    .frame_open(frame_open),
    .err_flag  (err_flag)
  );

  pkt_beat_buf #(.LANES(LANES), .BYTE_W(BYTE_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_data (bus_wdata),
    .load_cnt  (load_cnt),
    .load_sop  (load_sop),
    .load_eop  (load_eop),
    .load_abort(load_abort),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_abort (out_abort),
    .busy      (busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) drop_q <= 1'b0;
    else        drop_q <= accept && hit_drop;
  end
  assign drop_pulse = drop_q;

  a_r9_drop_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    drop_pulse |-> $past(bus_wr && (bus_addr == ADDR_W'(A_DROP))));
  a_r8_wait_means_pending: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wait |-> out_valid);
  a_r3_sop_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> frame_open);

endmodule

// File: tb/pkt_inject_port_bench.sv
`timescale 1ns/1ps
module pkt_inject_port_bench;

  typedef struct packed {
    logic [1:0]  op;    // equals the register address: 0 data, 1 cmd, 2 drop, 3 clear
    logic [15:0] val;
    logic        wide;
    logic [2:0]  n;
    logic [7:0]  b0;
    logic [7:0]  b1;
    logic [1:0]  sop;
    logic [1:0]  eop;
    logic [1:0]  abt;
    logic [1:0]  drop;
    logic        err;
    logic [3:0]  req;
  } row_t;

  localparam int NROWS = 38;
  localparam row_t ROWS [0:NROWS-1] = '{
    '{2'd0, 16'h00AA, 1'b1, 3'd0, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 2'd0, 1'b1, 4'd1}, // R1
    '{2'd3, 16'h0000, 1'b0, 3'd0, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 4'd7}, // R7
    '{2'd1, 16'h0001, 1'b0, 3'd0, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 4'd2}, // R2
    '{2'd0, 16'hA1B2, 1'b1, 3'd2, 8'hB2, 8'hA1, 2'd1, 2'd0, 2'd0, 2'd0, 1'b0, 4'd3}, // R3
    '{2'd0, 16'hFFC3, 1'b0, 3'd1, 8'hC3, 8'h00, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 4'd4}, // R4
    '{2'd0, 16'h1234, 1'b1, 3'd2, 8'h34, 8'h12, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 4'd4}, // R4
    '{2'd1, 16'h0004, 1'b0, 3'd0, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 4'd5}, // R5
    '{2'd0, 16'h5678, 1'b1, 3'd2, 8'h78, 8'h56, 2'd0, 2'd1, 2'd0, 2'd0, 1'b0, 4'd5}, // R5
    '{2'd0, 16'h9999, 1'b1, 3'd0, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 2'd0, 1'b1, 4'd5}, // R5
    '{2'd3, 16'h0000, 1'b0, 3'd0, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 4'd7}, // R7
    '{2'd1, 16'h0001, 1'b0, 3'd0, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 4'd2}, // R2
    '{2'd0, 16'h7711, 1'b0, 3'd1, 8'h11, 8'h00, 2'd1, 2'd0, 2'd0, 2'd0, 1'b0, 4'd4}, // R4
    '{2'd1, 16'h0005, 1'b0, 3'd0, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 4'd5}, // R5
    '{2'd0, 16'hEEDD, 1'b1, 3'd1, 8'hDD, 8'h00, 2'd0, 2'd1, 2'd0, 2'd0, 1'b0, 4'd5}, // R5
    '{2'd1, 16'h0002, 1'b0, 3'd0, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 2'd0, 1'b1, 4'd7}, // R7
    '{2'd0, 16'h4444, 1'b1, 3'd0, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 2'd0, 1'b1, 4'd7}, // R7
    '{2'd3, 16'h0000, 1'b0, 3'd0, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 4'd7}, // R7
    '{2'd1, 16'h0001, 1'b0, 3'd0, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 4'd2}, // R2
    '{2'd0, 16'h2233, 1'b1, 3'd2, 8'h33, 8'h22, 2'd1, 2'd0, 2'd0, 2'd0, 1'b0, 4'd3}, // R3
    '{2'd1, 16'h0003, 1'b0, 3'd1, 8'h00, 8'h00, 2'd0, 2'd0, 2'd1, 2'd0, 1'b0, 4'd6}, // R6
    '{2'd0, 16'h4455, 1'b1, 3'd0, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 2'd0, 1'b1, 4'd6}, // R6
    '{2'd3, 16'h0000, 1'b0, 3'd0, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 4'd7}, // R7
    '{2'd1, 16'h0003, 1'b0, 3'd0, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 4'd6}, // R6
    '{2'd1, 16'h0006, 1'b0, 3'd0, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 2'd0, 1'b1, 4'd7}, // R7
    '{2'd3, 16'h0000, 1'b0, 3'd0, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 4'd7}, // R7
    '{2'd1, 16'h0007, 1'b0, 3'd0, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 2'd0, 1'b1, 4'd7}, // R7
    '{2'd0, 16'h0102, 1'b1, 3'd0, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 2'd0, 1'b1, 4'd7}, // R7
    '{2'd3, 16'h0000, 1'b0, 3'd0, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 4'd7}, // R7
    '{2'd2, 16'h0000, 1'b0, 3'd0, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 2'd1, 1'b0, 4'd9}, // R9
    '{2'd1, 16'h0001, 1'b0, 3'd0, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 4'd2}, // R2
    '{2'd0, 16'h6655, 1'b1, 3'd2, 8'h55, 8'h66, 2'd1, 2'd0, 2'd0, 2'd0, 1'b0, 4'd3}, // R3
    '{2'd1, 16'h0001, 1'b0, 3'd0, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 2'd0, 1'b1, 4'd7}, // R7
    '{2'd3, 16'h0000, 1'b0, 3'd0, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 4'd7}, // R7
    '{2'd0, 16'h8877, 1'b1, 3'd2, 8'h77, 8'h88, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 4'd7}, // R7
    '{2'd1, 16'h0004, 1'b0, 3'd0, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 4'd5}, // R5
    '{2'd0, 16'hCDAB, 1'b0, 3'd1, 8'hAB, 8'h00, 2'd0, 2'd1, 2'd0, 2'd0, 1'b0, 4'd5}, // R5
    '{2'd1, 16'h0005, 1'b0, 3'd0, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 2'd0, 1'b1, 4'd7}, // R7
    '{2'd3, 16'h0000, 1'b0, 3'd0, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 4'd7}  // R7
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_wide = 1'b0;
  logic        out_ready = 1'b1;
  logic        bus_wait, out_valid, out_sop, out_eop, out_abort, drop_pulse, err_flag;
  logic [7:0]  out_data;

  always #10 clk = ~clk;

  pkt_inject_port u_pkt_inject_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wide(bus_wide), .bus_wait(bus_wait),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .out_abort(out_abort),
    .drop_pulse(drop_pulse), .err_flag(err_flag)
  );

  int n_run = 0, n_fail = 0, cyc = 0;
  int cap_n, sop_n, eop_n, abt_n, drop_n;
  logic [7:0] cap [0:7];

  // transfers are sampled half a cycle before the edge that takes them
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) begin
        if (cap_n < 8) cap[cap_n] = out_data;
        if (out_sop) sop_n++;
        if (out_eop) eop_n++;
        if (out_abort) abt_n++;
        cap_n++;
      end
      if (drop_pulse) drop_n++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual %0d cycles, expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic clr_cap();
    cap_n = 0; sop_n = 0; eop_n = 0; abt_n = 0; drop_n = 0;
    for (int i = 0; i < 8; i++) cap[i] = 8'h00;
  endtask

  task automatic check(input bit ok, input int req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d, input logic w);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wide = w;
    #2;
    while (bus_wait) begin @(negedge clk); #2; end
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_row(input row_t r);
    logic [46:0] act, exp;
    clr_cap();
    bus_write({1'b0, r.op}, r.val, r.wide);
    repeat (4) @(negedge clk);
    act = {3'(cap_n), cap[0], cap[1], 2'(sop_n), 2'(eop_n), 2'(abt_n), 2'(drop_n), err_flag};
    exp = {r.n, r.b0, r.b1, r.sop, r.eop, r.abt, r.drop, r.err};
    check(act == exp, int'(r.req), "row stream/flags", 64'(act), 64'(exp));
  endtask

  function automatic row_t mk(input logic [1:0] op, input logic [15:0] v, input logic w,
                              input logic [2:0] n, input logic [7:0] b0, input logic [7:0] b1,
                              input logic [1:0] s, input logic [1:0] e, input logic [1:0] ab,
                              input logic er, input logic [3:0] rq);
    row_t r;
    r = '{op, v, w, n, b0, b1, s, e, ab, 2'd0, er, rq};
    return r;
  endfunction

  initial begin
    clr_cap();
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!out_valid && !bus_wait && !drop_pulse && !err_flag, 1, "reset outputs",
          64'({out_valid, bus_wait, drop_pulse, err_flag}), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !err_flag, 1, "after release", 64'({out_valid, err_flag}), 64'(0));

    for (int i = 0; i < NROWS; i++) do_row(ROWS[i]);

    // R8: held write while the sink stalls
    do_row(mk(2'd1, 16'h0001, 1'b0, 3'd0, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 1'b0, 4'd2));
    @(posedge clk); #1 out_ready = 1'b0;
    clr_cap();
    bus_write(3'd0, 16'hBEEF, 1'b1);
    check(out_valid && out_data == 8'hEF && out_sop, 8, "first byte shown",
          64'({out_valid, out_data, out_sop}), 64'({1'b1, 8'hEF, 1'b1}));
    bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 16'h0102; bus_wide = 1'b1;
    #2;
    check(bus_wait == 1'b1, 8, "wait raised", 64'(bus_wait), 64'(1));
    repeat (3) @(negedge clk);
    check(bus_wait && out_valid && out_data == 8'hEF && out_sop, 8, "stall stable",
          64'({bus_wait, out_valid, out_data, out_sop}), 64'({1'b1, 1'b1, 8'hEF, 1'b1}));
    @(posedge clk); #1 out_ready = 1'b1;
    @(negedge clk); #2;
    while (bus_wait) begin @(negedge clk); #2; end
    @(negedge clk);
    bus_wr = 1'b0;
    repeat (4) @(negedge clk);
    check(cap_n == 4 && cap[0] == 8'hEF && cap[1] == 8'hBE && cap[2] == 8'h02 &&
          cap[3] == 8'h01 && sop_n == 1, 8, "held write delivered",
          64'({8'(cap_n), cap[0], cap[1], cap[2], cap[3]}),
          64'({8'd4, 8'hEF, 8'hBE, 8'h02, 8'h01}));
    do_row(mk(2'd1, 16'h0005, 1'b0, 3'd0, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 1'b0, 4'd5));
    do_row(mk(2'd0, 16'h0033, 1'b1, 3'd1, 8'h33, 8'h00, 2'd0, 2'd1, 2'd0, 1'b0, 4'd5));

    // R9: drop strobe in the same cycle as a stream beat
    do_row(mk(2'd1, 16'h0001, 1'b0, 3'd0, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 1'b0, 4'd2));
    clr_cap();
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 16'h7788; bus_wide = 1'b1;
    #2;
    @(negedge clk);
    bus_addr = 3'd2;
    @(negedge clk);
    check(drop_pulse && out_valid && out_data == 8'h77, 9, "drop with beat",
          64'({drop_pulse, out_valid, out_data}), 64'({1'b1, 1'b1, 8'h77}));
    bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    check(cap_n == 2 && cap[0] == 8'h88 && cap[1] == 8'h77 && drop_n == 1 && sop_n == 1, 9,
          "stream intact after drop", 64'({8'(cap_n), cap[0], cap[1], 8'(drop_n)}),
          64'({8'd2, 8'h88, 8'h77, 8'd1}));
    do_row(mk(2'd1, 16'h0003, 1'b0, 3'd1, 8'h00, 8'h00, 2'd0, 2'd0, 2'd1, 1'b0, 4'd6));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule